// File: doc/BRIEF.md
# Configuration Register Access-Sequence Detector

This block sits on the device side of an asynchronous 16-bit pseudo-SRAM. It watches the decoded bus operations that reach the memory array and spots a reserved four-operation pattern aimed at the highest word address. A completed pattern either loads a configuration word from the data bus or returns that word in place of array data. Software can therefore reach the configuration word without a dedicated pin or address window.

Each clock cycle carries at most one decoded operation: a read strobe or a write strobe, with its address and write data. The array side gets two controls from the block. A write-inhibit keeps the top word intact while the pattern is in progress. A read override, with its data, replaces array data on the qualifying read. A separate pin-driven load path can still write the configuration word. The first software load also raises a sticky flag that tells the refresh logic to stop taking partial-array refresh enable from the sleep pin. That flag stays set until power-on reset.

Top module: `cfg_seq_detect`

## Requirements
- R1: After power-on reset (synchronous, `rst_n` low), `cfg_q` equals the parameter `CFG_RST`, `pin_par_off` is 0, and the pattern tracker is idle.
- R2: The pattern is four consecutive operations at the top address (all address bits 1): read, read, write of the key word, then a fourth operation. Cycles with neither strobe do not break or advance it. An operation with both strobes high counts as a write.
- R3: If the fourth operation is a write at the top address, its data is loaded into `cfg_q` and is visible from the next cycle. No other write changes `cfg_q` through this path.
- R4: If the fourth operation is a read at the top address, `rd_ovr` is 1 in that same cycle and `rd_ovr_data` equals `cfg_q`. In all other cycles `rd_ovr` is 0 and `rd_ovr_data` is 0.
- R5: `arr_wr_inhibit` is 1, combinationally in the same cycle, only for the key write (step three) and the loading write (step four). It is 0 for every read and for every other write.
- R6: Any operation to another address returns the tracker to idle. So does a write at the top address in the idle or one-read state, or a step-three write whose data is not the key word (0). The step-three write with wrong data is not inhibited.
- R7: A further read at the top address after two qualifying reads keeps the two-read progress, so a longer run of reads still leads into step three.
- R8: `pin_par_off` becomes 1 on the cycle after the first software load and stays 1 until reset. A pattern that ends in a read does not set it.
- R9: A pulse on `pin_ld` loads `pin_data` into `cfg_q` on the next cycle. It leaves `pin_par_off` and the tracker unchanged. If the pin load and a software load fall in the same cycle, the software value is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| op_rd | input | 1 | Read operation strobe for this cycle |
| op_wr | input | 1 | Write operation strobe for this cycle |
| op_addr | input | ADDR_W | Word address of the operation |
| op_wdata | input | DATA_W | Write data of the operation |
| pin_ld | input | 1 | Load strobe from the pin-controlled path |
| pin_data | input | DATA_W | Value for the pin-controlled load |
| cfg_q | output | DATA_W | Current configuration word |
| rd_ovr | output | 1 | Replace array read data on this read |
| rd_ovr_data | output | DATA_W | Data to return when `rd_ovr` is 1 |
| arr_wr_inhibit | output | 1 | Block this write from reaching the array |
| pin_par_off | output | 1 | Sleep pin no longer enables partial-array refresh |

## Verification
The bench builds the block with `ADDR_W` = 8, `DATA_W` = 16 and `CFG_RST` = 16'h1234. The 8-bit address puts the top address at 8'hFF, so near-miss addresses such as 8'hFE are cheap to drive. The non-zero default makes the reset value easy to tell apart from a cleared or loaded word. With these values the bench reaches the complete load and read patterns, aborts on a foreign address and on a wrong key word, long runs of reads, and idle gaps inside a pattern. It also reaches a pin load that collides with a software load, and a repeat reset that clears the sticky flag.

// File: rtl/cfgseq_pkg.sv
// Package: shared types for the configuration access-sequence detector.
// Assumes: the sequence tracker needs four states, so two bits are enough.
package cfgseq_pkg;

    // Progress through the reserved four-operation pattern
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // nothing matched yet
        SQ_RD1  = 2'd1,   // one read at the top address seen
        SQ_RD2  = 2'd2,   // two (or more) reads at the top address seen
        SQ_KEY  = 2'd3    // key write accepted, the next operation is the payload
    } seq_state_e;

    // Kind of bus operation presented in a cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

endpackage

// File: rtl/cfgseq_op_decode.sv
// Module: cfgseq_op_decode
// Sorts the operation in the current cycle into none / read / write. It also
// flags a hit on the highest word address and a write data value equal to the
// key word. Purely combinational.
// Assumes: at most one strobe is meant per cycle; both high count as a write.
module cfgseq_op_decode
    import cfgseq_pkg::*;
#(
    parameter int                ADDR_W = 19,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY    = '0
) (
    input  logic              op_rd,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output op_kind_e          kind,
    output logic              at_top,
    output logic              key_ok
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    // Pick the operation kind; the write strobe wins a tie
    always_comb begin
        if (op_wr) begin
            kind = OP_WRITE;
        end else if (op_rd) begin
            kind = OP_READ;
        end else begin
            kind = OP_NONE;
        end
    end

    // Address and key comparisons
    always_comb begin
        at_top = (op_addr == TOP_ADDR);
        key_ok = (op_wdata == KEY);
    end

endmodule

// File: rtl/cfgseq_tracker.sv
// Module: cfgseq_tracker
// Follows the read, read, key-write, payload pattern at the top address. For
// the current operation it gives the array write-inhibit, the read override
// and the software-load strobe, all combinationally.
// Assumes: the inputs come from cfgseq_op_decode in the same cycle; the reset
// is synchronous and active low.
module cfgseq_tracker
    import cfgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_kind_e   kind,
    input  logic       at_top,
    input  logic       key_ok,
    output logic       sw_ld_stb,
    output logic       rd_ovr,
    output logic       wr_inhibit
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next state and per-operation outputs
    always_comb begin
        state_d    = state_q;
        sw_ld_stb  = 1'b0;
        rd_ovr     = 1'b0;
        wr_inhibit = 1'b0;
        if (kind != OP_NONE) begin
            if (!at_top) begin
                state_d = SQ_IDLE;
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        state_d = (kind == OP_READ) ? SQ_RD1 : SQ_IDLE;
                    end
                    SQ_RD1: begin
                        state_d = (kind == OP_READ) ? SQ_RD2 : SQ_IDLE;
                    end
                    SQ_RD2: begin
                        if (kind == OP_READ) begin
                            state_d = SQ_RD2;
                        end else if (key_ok) begin
                            state_d    = SQ_KEY;
                            wr_inhibit = 1'b1;
                        end else begin
                            state_d = SQ_IDLE;
                        end
                    end
                    SQ_KEY: begin
                        state_d = SQ_IDLE;
                        if (kind == OP_WRITE) begin
                            sw_ld_stb  = 1'b1;
                            wr_inhibit = 1'b1;
                        end else begin
                            rd_ovr = 1'b1;
                        end
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R4: the override only ever answers a read
    p_ovr_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ovr |-> (kind == OP_READ && at_top));

    // R5: the inhibit only ever applies to a write at the top address
    p_inhibit_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (kind == OP_WRITE && at_top));

    // R2: a completed pattern returns the tracker to idle
    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ld_stb || rd_ovr) |=> (state_q == SQ_IDLE));

    // R6: an operation to another address drops all progress
    p_foreign_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != OP_NONE && !at_top) |=> (state_q == SQ_IDLE));

    // R2: cycles without an operation hold the progress
    p_gap_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_NONE) |=> $stable(state_q));

endmodule

// File: rtl/cfgseq_cfg_reg.sv
// Module: cfgseq_cfg_reg
// Holds the configuration word and the sticky flag that records a software
// load. A software load wins over a pin load in the same cycle.
// Assumes: the reset is synchronous, active low and applied at power-up only.
module cfgseq_cfg_reg #(
    parameter int                DATA_W  = 16,
    parameter logic [DATA_W-1:0] CFG_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_ld,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              pin_ld,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] cfg_q,
    output logic              sw_loaded
);

    // Configuration word: software load first, then pin load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (sw_ld) begin
            cfg_q <= sw_data;
        end else if (pin_ld) begin
            cfg_q <= pin_data;
        end
    end

    // Sticky record of any software load, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_loaded <= 1'b0;
        end else if (sw_ld) begin
            sw_loaded <= 1'b1;
        end
    end

    // R3: a software load lands on the next cycle
    p_sw_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ld |=> (cfg_q == $past(sw_data)));

    // R9: a lone pin load lands on the next cycle
    p_pin_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ld && !sw_ld) |=> (cfg_q == $past(pin_data)));

    // R9: without any load the word holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_ld && !sw_ld) |=> $stable(cfg_q));

    // R8: once set, the flag stays set
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_loaded |=> sw_loaded);

endmodule

// File: rtl/cfg_seq_detect.sv
// Module: cfg_seq_detect (top)
// Spots the reserved four-operation pattern at the highest word address of a
// pseudo-SRAM. It loads or returns the configuration word, protects the top
// array word while the pattern runs, and reports that software has taken over
// partial-array refresh from the sleep pin.
// Assumes: one decoded operation per cycle; array storage and the pin-level
// refresh logic are outside this block.
module cfg_seq_detect
    import cfgseq_pkg::*;
#(
    parameter int                ADDR_W  = 19,
    parameter int                DATA_W  = 16,
    parameter logic [DATA_W-1:0] CFG_RST = 16'h0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_rd,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              pin_ld,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] cfg_q,
    output logic              rd_ovr,
    output logic [DATA_W-1:0] rd_ovr_data,
    output logic              arr_wr_inhibit,
    output logic              pin_par_off
);

    localparam logic [DATA_W-1:0] KEY_WORD = '0;

    op_kind_e kind;
    logic     at_top;
    logic     key_ok;
    logic     sw_ld_stb;
    logic     ovr;

    cfgseq_op_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY    (KEY_WORD)
    ) u_decode (
        .op_rd    (op_rd),
        .op_wr    (op_wr),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .kind     (kind),
        .at_top   (at_top),
        .key_ok   (key_ok)
    );

    cfgseq_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .at_top     (at_top),
        .key_ok     (key_ok),
        .sw_ld_stb  (sw_ld_stb),
        .rd_ovr     (ovr),
        .wr_inhibit (arr_wr_inhibit)
    );

    cfgseq_cfg_reg #(
        .DATA_W  (DATA_W),
        .CFG_RST (CFG_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_ld     (sw_ld_stb),
        .sw_data   (op_wdata),
        .pin_ld    (pin_ld),
        .pin_data  (pin_data),
        .cfg_q     (cfg_q),
        .sw_loaded (pin_par_off)
    );

    // Read override: present the configuration word only on the qualifying read
    always_comb begin
        rd_ovr      = ovr;
        rd_ovr_data = ovr ? cfg_q : '0;
    end

    // R4: override data outside a qualifying read is zero
    p_ovr_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ovr |-> (rd_ovr_data == '0));

    // R5: a read is never inhibited and never overridden alongside an inhibit
    p_no_inhibit_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_rd && !op_wr) |-> !arr_wr_inhibit);

endmodule

// File: tb/cfg_seq_detect_bench.sv
`timescale 1ns/1ps
module cfg_seq_detect_bench;

    localparam int          AW   = 8;
    localparam int          DW   = 16;
    localparam logic [15:0] RSTV = 16'h1234;
    localparam logic [7:0]  TOP  = 8'hFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_rd = 1'b0;
    logic          op_wr = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_wdata = '0;
    logic          pin_ld = 1'b0;
    logic [DW-1:0] pin_data = '0;
    logic [DW-1:0] cfg_q;
    logic          rd_ovr;
    logic [DW-1:0] rd_ovr_data;
    logic          arr_wr_inhibit;
    logic          pin_par_off;

    always #10 clk = ~clk;

    cfg_seq_detect #(.ADDR_W(AW), .DATA_W(DW), .CFG_RST(RSTV)) u_cfg_seq_detect (
        .clk(clk), .rst_n(rst_n), .op_rd(op_rd), .op_wr(op_wr),
        .op_addr(op_addr), .op_wdata(op_wdata), .pin_ld(pin_ld),
        .pin_data(pin_data), .cfg_q(cfg_q), .rd_ovr(rd_ovr),
        .rd_ovr_data(rd_ovr_data), .arr_wr_inhibit(arr_wr_inhibit),
        .pin_par_off(pin_par_off)
    );

    typedef struct {
        string       tag;
        logic        inh;
        logic        ovr;
        logic [15:0] ovr_data;
        logic [15:0] cfg;
        logic        par;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // Reference state built from the requirements
    int          m_st  = 0;
    logic [15:0] m_cfg = RSTV;
    logic        m_par = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected result for it
    task automatic do_op(input logic rd, input logic wr, input logic [7:0] a,
                         input logic [15:0] d, input logic pl,
                         input logic [15:0] pd, input string tag);
        exp_t e;
        logic inh;
        logic ovr;
        logic ld;
        @(negedge clk);
        op_rd = rd; op_wr = wr; op_addr = a; op_wdata = d;
        pin_ld = pl; pin_data = pd;
        inh = 1'b0; ovr = 1'b0; ld = 1'b0;
        e.cfg = m_cfg;
        e.par = m_par;
        if (rd || wr) begin
            if (a != TOP) begin
                m_st = 0;                        // R6
            end else if (m_st == 0) begin
                m_st = wr ? 0 : 1;
            end else if (m_st == 1) begin
                m_st = wr ? 0 : 2;
            end else if (m_st == 2) begin
                if (!wr) m_st = 2;               // R7
                else if (d == 16'h0000) begin inh = 1'b1; m_st = 3; end
                else m_st = 0;
            end else begin
                if (wr) begin inh = 1'b1; ld = 1'b1; end
                else ovr = 1'b1;
                m_st = 0;
            end
        end
        e.tag = tag;
        e.inh = inh;
        e.ovr = ovr;
        e.ovr_data = ovr ? m_cfg : 16'h0000;
        exp_q.push_back(e);
        if (ld) begin m_cfg = d; m_par = 1'b1; end
        else if (pl) m_cfg = pd;
    endtask

    task automatic idle(input string tag);
        do_op(1'b0, 1'b0, 8'h00, 16'h0000, 1'b0, 16'h0000, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_rd = 1'b0; op_wr = 1'b0; pin_ld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cfg = RSTV; m_par = 1'b0;
    endtask

    // Monitor: pop the expected item and compare late in the cycle
    always begin
        exp_t it;
        @(negedge clk);
        #8;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            chk(it.tag, "arr_wr_inhibit", {15'd0, arr_wr_inhibit}, {15'd0, it.inh});
            chk(it.tag, "rd_ovr", {15'd0, rd_ovr}, {15'd0, it.ovr});
            chk(it.tag, "rd_ovr_data", rd_ovr_data, it.ovr_data);
            chk(it.tag, "cfg_q", cfg_q, it.cfg);
            chk(it.tag, "pin_par_off", {15'd0, pin_par_off}, {15'd0, it.par});
        end
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic R = 1'b1;
    localparam logic N = 1'b0;

    initial begin
        do_reset();
        idle("R1");
        // R9: pin load before any software load, flag stays clear
        do_op(N, N, 8'h00, 16'h0000, 1'b1, 16'hBEEF, "R9");
        idle("R9");
        // R2 R3 R5 R8: full load pattern with an idle gap inside it
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R2");
        idle("R2");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R2");
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R5");
        do_op(N, R, TOP, 16'hA5C3, 1'b0, 16'h0000, "R3");
        idle("R8");
        // R4: read pattern returns the word
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R4");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R4");
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R5");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R4");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R4");
        // R6: foreign address breaks the pattern
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(R, N, 8'hFE, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h5555, 1'b0, 16'h0000, "R6");
        idle("R6");
        // R6: wrong key word aborts and is not inhibited
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h0001, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h6666, 1'b0, 16'h0000, "R6");
        idle("R6");
        // R7: long read run then the pattern, both strobes count as write,
        // and a pin load in the same cycle as the software load (R9)
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R7");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R7");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R7");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R7");
        do_op(R, R, TOP, 16'h0000, 1'b0, 16'h0000, "R7");
        do_op(N, R, TOP, 16'h0F0F, 1'b1, 16'h7777, "R9");
        idle("R9");
        // R9: pin load after software load keeps the flag
        do_op(N, N, 8'h00, 16'h0000, 1'b1, 16'h4321, "R9");
        idle("R8");
        // R1: reset clears the flag and restores the default
        do_reset();
        idle("R1");
        // R8: read-only pattern leaves the flag clear
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R8");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R8");
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R8");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R8");
        idle("R8");
        // R6: write at the top address from idle and one-read state
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(R, N, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h0000, 1'b0, 16'h0000, "R6");
        do_op(N, R, TOP, 16'h9999, 1'b0, 16'h0000, "R6");
        idle("R6");
        idle("R6");
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule